// File: doc/BRIEF.md
# Peripheral clock control slot

This block is a single control slot for one peripheral's functional clock, written as part of a larger clock controller. A 32-bit register is written whole and can be read back at any time. The register carries a clock gate, a source selector over seven incoming source strobes, a fractional-scale bit and a divider field. The output `clk_en` is a clock-enable strobe for the peripheral, built from the selected source. Every clock in the model is an enable strobe in the one system clock domain. No real clock is generated or switched.

The slot checks every write before taking it. The `slot_present` pin marks the slot as fitted. The `periph_busy` pin says the peripheral is in use. A write is refused when the slot is absent or in use. It is also refused when the gate is on and the write would alter the source or divider fields, or when it asks for the fractional bit together with a divisor of one. A refused write leaves the register exactly as it was and raises `wr_err` for one cycle. Two build parameters can remove the source selector (`HAS_SRC`) and the divider (`HAS_DIV`).

The rate generator is a small state machine with three states:
- **SL_OFF**: the gate is clear.
- **SL_PARKED**: the gate is set but the source code is 0.
- **SL_RUN**: the gate is set and a source is chosen.

Its transitions are:
- **arm**: OFF to PARKED.
- **start**: OFF or PARKED to RUN.
- **park**: RUN to PARKED.
- **stop**: PARKED or RUN to OFF.

In SL_RUN an accumulator adds FRAC+1 on each selected strobe. When the sum reaches PCD+1 it emits one output strobe and subtracts PCD+1. The accumulator is cleared whenever the state is not SL_RUN.

Top module: `periph_clk_slot`

## Requirements
- R1: After reset the gate, source, fractional bit and divider fields are all zero, `clk_en` is low, and `rd_data` shows only the live present and busy pins.
- R2: Register layout: bit 31 shows `slot_present` and bit 30 shows `periph_busy`; both are read-only and writes to them are ignored. Bit 29 is the gate, bits 26:24 the source code, bit 3 the fractional bit, and bits 2:0 the divider PCD, which holds the divisor minus one. All other bits read as zero.
- R3: While `slot_present` is low, every write is refused: the register is unchanged and `wr_err` is high for one cycle after the write.
- R4: While `periph_busy` is high, every write is refused in the same way as R3.
- R5: While the gate is set, a write that changes the source, fractional or divider field is refused. A write that keeps those fields and clears or keeps the gate is accepted, and `wr_err` stays low.
- R6: A write with the fractional bit set and PCD equal to 0 is refused.
- R7: Source code 0 gives no output strobes. Source code n (1 to 7) follows `src_tick[n-1]`, and strobes on other inputs have no effect.
- R8: With the gate set, N strobes of the selected source, counted from a cleared accumulator, give floor(N*(FRAC+1)/(PCD+1)) output strobes. Each output strobe appears one cycle after its source strobe.
- R9: With the gate clear, `clk_en` stays low and the accumulator is cleared.
- R10: `clk_active` is high exactly when `periph_busy` is high or the gate bit is set.
- R11: With `HAS_SRC`=0 and `HAS_DIV`=0, the source and divider fields read as zero and ignore writes. The slot then follows `src_tick[0]` one-to-one whenever the gate is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_present | input | 1 | Slot is fitted; writes are allowed only when high |
| periph_busy | input | 1 | Peripheral in-use status |
| src_tick | input | NSRC | One enable strobe per candidate source |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Register read value |
| wr_err | output | 1 | One-cycle pulse after a refused write |
| clk_active | output | 1 | Busy or gated-on indication |
| clk_en | output | 1 | Peripheral clock-enable strobe |

## Verification
A corrupted configuration field shows on `rd_data` in the cycle after the write that caused it. A wrong permission decision also flips `wr_err` in that same cycle, so both are caught at the write itself. A faulty accumulator or state register is quieter: it shows only as an output strobe count that differs from floor(N*(FRAC+1)/(PCD+1)). The bench therefore counts output strobes over bursts long enough that a one-off error in the accumulator or a wrong limit changes the total.

// File: rtl/periph_clk_slot_pkg.sv
package periph_clk_slot_pkg;

    localparam int REG_W    = 32;
    localparam int PRES_BIT = 31;
    localparam int BUSY_BIT = 30;
    localparam int GATE_BIT = 29;
    localparam int SRC_LSB  = 24;
    localparam int FRAC_BIT = 3;
    localparam int DIV_LSB  = 0;

    typedef enum logic [1:0] {
        SL_OFF    = 2'd0,
        SL_PARKED = 2'd1,
        SL_RUN    = 2'd2
    } slot_state_e;

endpackage

// File: rtl/pcs_cfg_reg.sv
module pcs_cfg_reg
    import periph_clk_slot_pkg::*;
#(
    parameter bit HAS_SRC = 1'b1,
    parameter bit HAS_DIV = 1'b1,
    parameter int SRCW    = 3,
    parameter int DIVW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             present,
    input  logic             busy,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic             gate_q,
    output logic [SRCW-1:0]  src_q,
    output logic             frac_q,
    output logic [DIVW-1:0]  pcd_q,
    output logic             wr_err
);

    logic [SRCW-1:0] wr_src;
    logic            wr_frac;
    logic [DIVW-1:0] wr_pcd;
    logic            fld_change;
    logic            bad_combo;
    logic            reject;
    logic            unused_wr;

    // Bits of wr_data that no field uses are gathered here.
    assign unused_wr = ^wr_data;

    // Absent fields read as zero and never count as a change.
    generate
        if (HAS_SRC) begin : g_src
            assign wr_src = wr_data[SRC_LSB +: SRCW];
        end else begin : g_nosrc
            assign wr_src = '0;
        end
        if (HAS_DIV) begin : g_div
            assign wr_frac = wr_data[FRAC_BIT];
            assign wr_pcd  = wr_data[DIV_LSB +: DIVW];
        end else begin : g_nodiv
            assign wr_frac = 1'b0;
            assign wr_pcd  = '0;
        end
    endgenerate

    always_comb begin
        fld_change = (wr_src != src_q) || (wr_frac != frac_q) || (wr_pcd != pcd_q);
        bad_combo  = wr_frac && (wr_pcd == '0);
        reject     = !present || busy || (gate_q && fld_change) || bad_combo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            src_q  <= '0;
            frac_q <= 1'b0;
            pcd_q  <= '0;
            wr_err <= 1'b0;
        end else begin
            wr_err <= wr_en && reject;
            if (wr_en && !reject) begin
                gate_q <= wr_data[GATE_BIT];
                src_q  <= wr_src;
                frac_q <= wr_frac;
                pcd_q  <= wr_pcd;
            end
        end
    end

    // R3: an absent slot takes no write.
    assert_absent_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !present) |=> ($stable({gate_q, src_q, frac_q, pcd_q}) && wr_err));

    // R4: a busy slot takes no write.
    assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> ($stable({gate_q, src_q, frac_q, pcd_q}) && wr_err));

    // R5: the source and divider fields stay frozen while the gate is on.
    assert_gated_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gate_q |=> $stable({src_q, frac_q, pcd_q}));

    // R6: the stored configuration never holds the fractional bit with PCD 0.
    assert_no_bad_combo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(frac_q && (pcd_q == '0)));

endmodule

// File: rtl/pcs_src_sel.sv
module pcs_src_sel #(
    parameter bit HAS_SRC = 1'b1,
    parameter int NSRC    = 7,
    parameter int SRCW    = 3
) (
    input  logic [NSRC-1:0] src_tick,
    input  logic [SRCW-1:0] src_code,
    output logic            sel_tick,
    output logic            src_ok
);

    generate
        if (HAS_SRC) begin : g_mux
            always_comb begin
                sel_tick = 1'b0;
                for (int i = 0; i < NSRC; i++) begin
                    if (src_code == SRCW'(i + 1)) begin
                        sel_tick = src_tick[i];
                    end
                end
                src_ok = (src_code != '0);
            end
        end else begin : g_fixed
            logic unused_code;
            assign unused_code = ^{src_code, src_tick[NSRC-1:1]};
            assign sel_tick    = src_tick[0];
            assign src_ok      = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/pcs_rate_gen.sv
module pcs_rate_gen
    import periph_clk_slot_pkg::*;
#(
    parameter int DIVW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gate,
    input  logic            src_ok,
    input  logic            tick,
    input  logic            frac,
    input  logic [DIVW-1:0] pcd,
    output logic            en_o
);

    localparam int ACCW = DIVW + 1;

    slot_state_e     state_q, state_d;
    logic [ACCW-1:0] acc_q;
    logic [ACCW-1:0] inc, lim, sum;
    logic            reach;

    always_comb begin
        inc   = ACCW'(frac) + ACCW'(1);
        lim   = ACCW'(pcd) + ACCW'(1);
        sum   = acc_q + inc;
        reach = (sum >= lim);
    end

    // Next-state logic: arm, start, park, stop.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SL_OFF: begin
                if (gate && src_ok)  state_d = SL_RUN;
                else if (gate)       state_d = SL_PARKED;
            end
            SL_PARKED: begin
                if (!gate)           state_d = SL_OFF;
                else if (src_ok)     state_d = SL_RUN;
            end
            SL_RUN: begin
                if (!gate)           state_d = SL_OFF;
                else if (!src_ok)    state_d = SL_PARKED;
            end
            default:                 state_d = SL_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SL_OFF;
        else        state_q <= state_d;
    end

    // Output process: accumulator and enable strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            en_o  <= 1'b0;
        end else if (state_d != SL_RUN) begin
            acc_q <= '0;
            en_o  <= 1'b0;
        end else if (tick) begin
            en_o  <= reach;
            acc_q <= reach ? (sum - lim) : sum;
        end else begin
            en_o  <= 1'b0;
        end
    end

    // R9: no strobe unless the machine sits in SL_RUN.
    assert_quiet_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SL_RUN) |-> !en_o);

    // R8: the remainder stays below the divisor.
    assert_acc_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q <= ACCW'(pcd));

    // R8: a strobe needs a source strobe on the cycle before.
    assert_strobe_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |-> $past(tick));

endmodule

// File: rtl/periph_clk_slot.sv
module periph_clk_slot
    import periph_clk_slot_pkg::*;
#(
    parameter bit HAS_SRC = 1'b1,
    parameter bit HAS_DIV = 1'b1,
    parameter int NSRC    = 7,
    parameter int DIVW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_present,
    input  logic             periph_busy,
    input  logic [NSRC-1:0]  src_tick,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             wr_err,
    output logic             clk_active,
    output logic             clk_en
);

    localparam int SRCW = $clog2(NSRC + 1);

    logic            gate_q;
    logic [SRCW-1:0] src_q;
    logic            frac_q;
    logic [DIVW-1:0] pcd_q;
    logic            sel_tick;
    logic            src_ok;

    pcs_cfg_reg #(
        .HAS_SRC (HAS_SRC),
        .HAS_DIV (HAS_DIV),
        .SRCW    (SRCW),
        .DIVW    (DIVW)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .present (slot_present),
        .busy    (periph_busy),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .gate_q  (gate_q),
        .src_q   (src_q),
        .frac_q  (frac_q),
        .pcd_q   (pcd_q),
        .wr_err  (wr_err)
    );

    pcs_src_sel #(
        .HAS_SRC (HAS_SRC),
        .NSRC    (NSRC),
        .SRCW    (SRCW)
    ) u_sel (
        .src_tick (src_tick),
        .src_code (src_q),
        .sel_tick (sel_tick),
        .src_ok   (src_ok)
    );

    pcs_rate_gen #(
        .DIVW (DIVW)
    ) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .gate   (gate_q),
        .src_ok (src_ok),
        .tick   (sel_tick),
        .frac   (frac_q),
        .pcd    (pcd_q),
        .en_o   (clk_en)
    );

    always_comb begin
        rd_data                      = '0;
        rd_data[PRES_BIT]            = slot_present;
        rd_data[BUSY_BIT]            = periph_busy;
        rd_data[GATE_BIT]            = gate_q;
        rd_data[SRC_LSB +: SRCW]     = src_q;
        rd_data[FRAC_BIT]            = frac_q;
        rd_data[DIV_LSB +: DIVW]     = pcd_q;
    end

    assign clk_active = periph_busy || gate_q;

    // R7: source code 0 never yields a strobe.
    assert_src_zero_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !src_ok |-> !clk_en);

endmodule

// File: tb/periph_clk_slot_tb.sv
module periph_clk_slot_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_present = 1'b1;
    logic        periph_busy = 1'b0;
    logic [6:0]  src_tick = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        wr_err;
    logic        clk_active;
    logic        clk_en;

    logic        wr_en_b = 1'b0;
    logic [31:0] rd_data_b;
    logic        wr_err_b;
    logic        clk_active_b;
    logic        clk_en_b;

    int n_total = 0;
    int n_fail  = 0;
    int pulse_a = 0;
    int pulse_b = 0;
    bit done    = 1'b0;

    bit    exp_err_q[$];
    string exp_tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    periph_clk_slot dut_i (
        .clk (clk), .rst_n (rst_n), .slot_present (slot_present),
        .periph_busy (periph_busy), .src_tick (src_tick), .wr_en (wr_en),
        .wr_data (wr_data), .rd_data (rd_data), .wr_err (wr_err),
        .clk_active (clk_active), .clk_en (clk_en)
    );

    periph_clk_slot #(.HAS_SRC(1'b0), .HAS_DIV(1'b0)) dut_nf (
        .clk (clk), .rst_n (rst_n), .slot_present (1'b1),
        .periph_busy (1'b0), .src_tick (src_tick), .wr_en (wr_en_b),
        .wr_data (wr_data), .rd_data (rd_data_b), .wr_err (wr_err_b),
        .clk_active (clk_active_b), .clk_en (clk_en_b)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: queue the expected error flag, then issue the write.
    task automatic wr(input logic [31:0] d, input bit exp_err, input string tag);
        @(negedge clk);
        exp_err_q.push_back(exp_err);
        exp_tag_q.push_back(tag);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Monitor: pop one expectation per write and compare wr_err.
    initial begin
        forever begin
            @(posedge clk);
            if (wr_en && rst_n) begin
                bit    e;
                string t;
                e = exp_err_q.pop_front();
                t = exp_tag_q.pop_front();
                @(negedge clk);
                chk({t, " wr_err"}, {31'd0, wr_err}, {31'd0, e});
            end
        end
    end

    always @(negedge clk) begin
        if (clk_en)   pulse_a++;
        if (clk_en_b) pulse_b++;
    end

    task automatic run_ticks(input logic [6:0] m, input int n);
        @(negedge clk);
        pulse_a = 0;
        pulse_b = 0;
        for (int i = 0; i < n; i++) begin
            src_tick = m;
            @(negedge clk);
            src_tick = '0;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (CLK_PERIOD * 10000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd_data", rd_data, 32'h8000_0000);
        chk("R1 clk_en", {31'd0, clk_en}, 32'd0);
        chk("R10 idle active", {31'd0, clk_active}, 32'd0);

        // R2 layout: gate on, source 3, divisor 1; read-only bits ignored
        wr(32'hE300_0000, 1'b0, "R2 write");
        chk("R2 readback", rd_data, 32'hA300_0000);
        chk("R10 gated active", {31'd0, clk_active}, 32'd1);
        run_ticks(7'b000_0100, 10);
        chk("R8 div1 count", pulse_a, 10);
        run_ticks(7'b111_1011, 5);
        chk("R7 other sources", pulse_a, 0);

        // R5 gated writes
        wr(32'h2500_0000, 1'b1, "R5 src change gated");
        chk("R5 unchanged", rd_data, 32'hA300_0000);
        wr(32'h0300_0000, 1'b0, "R5 gate off");
        chk("R5 gate off rd", rd_data, 32'h8300_0000);
        run_ticks(7'b000_0100, 6);
        chk("R9 gate off quiet", pulse_a, 0);

        // R8 divide by 4
        wr(32'h2300_0003, 1'b0, "R8 div4 write");
        chk("R8 div4 rd", rd_data, 32'hA300_0003);
        run_ticks(7'b000_0100, 12);
        chk("R8 div4 count", pulse_a, 3);
        wr(32'h0300_0003, 1'b0, "R8 div4 off");

        // R6 illegal combination
        wr(32'h0300_0008, 1'b1, "R6 frac with pcd0");
        chk("R6 unchanged", rd_data, 32'h8300_0003);

        // R8 fractional 2/3
        wr(32'h2300_000A, 1'b0, "R8 frac write");
        run_ticks(7'b000_0100, 9);
        chk("R8 frac count", pulse_a, 6);
        wr(32'h0300_000A, 1'b0, "R8 frac off");

        // R4 busy
        periph_busy = 1'b1;
        @(negedge clk);
        chk("R10 busy active", {31'd0, clk_active}, 32'd1);
        wr(32'h0100_0001, 1'b1, "R4 busy write");
        chk("R4 unchanged", rd_data, 32'hC300_000A);
        periph_busy = 1'b0;

        // R3 absent
        slot_present = 1'b0;
        wr(32'h0100_0001, 1'b1, "R3 absent write");
        chk("R3 unchanged", rd_data, 32'h0300_000A);
        slot_present = 1'b1;

        // R7 source 0 with gate on
        wr(32'h2000_0000, 1'b0, "R7 src0 write");
        chk("R7 src0 rd", rd_data, 32'hA000_0000);
        run_ticks(7'b111_1111, 4);
        chk("R7 src0 quiet", pulse_a, 0);

        // R11 slot without source and divider fields
        chk("R11 reset rd", rd_data_b, 32'h8000_0000);
        @(negedge clk);
        wr_data = 32'h2700_000F;
        wr_en_b = 1'b1;
        @(negedge clk);
        wr_en_b = 1'b0;
        chk("R11 err", {31'd0, wr_err_b}, 32'd0);
        chk("R11 rd fields zero", rd_data_b, 32'hA000_0000);
        run_ticks(7'b000_0001, 5);
        chk("R11 follows src0", pulse_b, 5);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule